// File: doc/BRIEF.md
# Address Translation Cache with Transparent Windows

This block turns logical addresses into physical addresses for a single access stream. A fully associative cache of page translations works alongside a small set of transparent windows. A window is a register that marks a large region of the address space as untranslated and gives that region its own attributes. When a request is accepted, the block takes the first source that applies, in this order:

1. Global translation is switched off: identity mapping with the default attributes.
2. A window matches: identity mapping with that window's attributes.
3. The cache holds the page: the cached physical page and the cached attributes.

If none of these applies, the block asks an external table walker for the translation. The block stalls until the walker answers. It then installs the returned translation and completes the access that was waiting.

Pages are 4 KiB and addresses are 32 bits, so the page tag is address bits [31:12]. Each cache entry records whether its page has been written. A write to a page whose entry is still clean goes back to the walker, so that the written flag can be set in memory. The returned entry is then written over the same slot. A flush input empties the cache in one cycle.

Top module: `atc_top`

## Requirements
- R1: When `xlate_en` is 0, an accepted request answers one cycle later with `resp_paddr` equal to the request address, the default attributes, and `resp_src` = 0 (default). No walk is requested.
- R2: A window matches when its enable bit is 1 and address bits [31:24] equal its base in every bit position where its mask bit is 0. A mask bit of 1 means "don't care". A matching window gives `resp_src` = 1, an identity `resp_paddr` and that window's attributes. A window whose enable bit is 0 never matches.
- R3: Window 0 takes priority over window 1. Any matching window takes priority over a cache hit for the same address.
- R4: A cache hit answers one cycle after acceptance with `resp_src` = 2. `resp_paddr` is the stored physical page joined to address bits [11:0], and the attributes are those of the stored entry.
- R5: On a miss, `walk_req` rises one cycle after acceptance, with `walk_vpn` = address bits [31:12] and `walk_write` = the request's write flag. While `walk_req` is high, `req_ready` is 0 and `walk_vpn` holds steady until `walk_ack`.
- R6: In the cycle after `walk_ack`, the block answers with `resp_src` = 3, the returned physical page joined to the page offset, and the returned attributes. After that, the same page hits in the cache.
- R7: A write that hits an entry whose written flag is clear is handled as a miss with `walk_write` = 1. The refill overwrites the same slot with the written flag set, so later writes to that page hit. A read to a clean page hits.
- R8: A refill goes to the lowest-numbered invalid entry. When every entry is valid, the victim is chosen by a round-robin pointer that starts at entry 0 after reset or flush and advances on each such eviction.
- R9: A flush pulse invalidates every entry in one cycle, so that the next lookup of any page misses. If a flush and `walk_ack` arrive in the same cycle, the flush wins and nothing is installed.
- R10: No two valid entries ever hold the same page tag.
- R11: After reset, `resp_valid` and `walk_req` are 0, `req_ready` is 1, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Global translation enable |
| flush | input | 1 | Invalidate all cache entries |
| def_cmode | input | 2 | Default cache mode |
| def_wprot | input | 1 | Default write protection |
| def_user | input | 2 | Default user attributes |
| win_en | input | NWIN | Window enable bits |
| win_base | input | NWIN*8 | Window base, address bits [31:24] |
| win_mask | input | NWIN*8 | Window don't-care mask |
| win_cmode | input | NWIN*2 | Window cache modes |
| win_wprot | input | NWIN | Window write protection |
| win_user | input | NWIN*2 | Window user attributes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Logical address |
| req_write | input | 1 | Request is a write |
| resp_valid | output | 1 | Response valid (one-cycle pulse) |
| resp_paddr | output | AW | Physical address |
| resp_cmode | output | 2 | Cache mode |
| resp_wprot | output | 1 | Write protection |
| resp_user | output | 2 | User attributes |
| resp_src | output | 2 | Source of the translation: 0 default, 1 window, 2 cache, 3 refill |
| walk_req | output | 1 | Table walk request |
| walk_vpn | output | AW-12 | Page number to walk |
| walk_write | output | 1 | Walk was caused by a write |
| walk_ack | input | 1 | Walker returns a translation |
| walk_ppn | input | AW-12 | Returned physical page |
| walk_cmode | input | 2 | Returned cache mode |
| walk_wprot | input | 1 | Returned write protection |
| walk_user | input | 2 | Returned user attributes |

## Verification
The hardest state to reach from the ports is round-robin eviction. It needs all 64 entries valid at once, and that only happens after 64 separate walk round trips with distinct page numbers. The bench fills the cache this way and then installs one more page. It then probes neighbouring pages, so that each step's hit or miss exposes which slot the pointer chose. The written-flag upgrade is reached by reading a page first, so that it installs clean, and only then writing it. The window-over-cache priority is reached by caching a page while the windows are off, then enabling overlapping windows over that address.

// File: rtl/atc_pkg.sv
package atc_pkg;
  localparam int ATC_WIN_BITS = 8;

  typedef struct packed {
    logic [1:0] cmode;
    logic       wprot;
    logic [1:0] user;
  } atc_attr_t;

  typedef enum logic [1:0] {
    SRC_DEF    = 2'd0,
    SRC_WIN    = 2'd1,
    SRC_CACHE  = 2'd2,
    SRC_REFILL = 2'd3
  } atc_src_e;

  // region test: bits set in mask are ignored
  function automatic logic win_match(input logic [ATC_WIN_BITS-1:0] hi,
                                     input logic [ATC_WIN_BITS-1:0] base,
                                     input logic [ATC_WIN_BITS-1:0] mask,
                                     input logic en);
    return en && (((hi ^ base) & ~mask) == '0);
  endfunction
endpackage

// File: rtl/atc_window.sv
module atc_window
  import atc_pkg::*;
#(
  parameter int NWIN = 2,
  parameter int AW   = 32
) (
  input  logic [AW-1:0]              addr,
  input  logic [NWIN-1:0]            en,
  input  logic [NWIN*ATC_WIN_BITS-1:0] base,
  input  logic [NWIN*ATC_WIN_BITS-1:0] mask,
  input  logic [NWIN*2-1:0]          cmode,
  input  logic [NWIN-1:0]            wprot,
  input  logic [NWIN*2-1:0]          user,
  output logic                       any_hit,
  output atc_attr_t                  attr
);
  logic [NWIN-1:0] hit_vec;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign hit_vec[g] = win_match(addr[AW-1 -: ATC_WIN_BITS],
                                  base[g*ATC_WIN_BITS +: ATC_WIN_BITS],
                                  mask[g*ATC_WIN_BITS +: ATC_WIN_BITS],
                                  en[g]);
  end

  assign any_hit = |hit_vec;

  // walk from highest to lowest so the lowest index wins
  always_comb begin
    attr = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        attr.cmode = cmode[i*2 +: 2];
        attr.wprot = wprot[i];
        attr.user  = user[i*2 +: 2];
      end
    end
  end

  // R3: window 0 owns the attributes whenever it matches
  always_comb begin
    if (hit_vec[0]) begin
      assert_win0_first_R3: assert (attr.cmode == cmode[1:0] && attr.user == user[1:0]
                                    && attr.wprot == wprot[0]);
    end
  end
endmodule

// File: rtl/atc_tag_store.sv
module atc_tag_store
  import atc_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [VPN_W-1:0]             lk_vpn,
  output logic                         lk_hit,
  output logic [$clog2(ENTRIES)-1:0]   lk_idx,
  output logic [PPN_W-1:0]             lk_ppn,
  output atc_attr_t                    lk_attr,
  output logic                         lk_dirty,
  input  logic                         ins_en,
  input  logic                         ins_reuse,
  input  logic [$clog2(ENTRIES)-1:0]   ins_reuse_idx,
  input  logic [VPN_W-1:0]             ins_vpn,
  input  logic [PPN_W-1:0]             ins_ppn,
  input  atc_attr_t                    ins_attr,
  input  logic                         ins_dirty
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid;
  logic [VPN_W-1:0]   tag   [ENTRIES];
  logic [PPN_W-1:0]   ppn   [ENTRIES];
  atc_attr_t          attr  [ENTRIES];
  logic [ENTRIES-1:0] dirty;
  logic [IDX_W-1:0]   rr_ptr;
  logic [ENTRIES-1:0] match;

  function automatic logic [IDX_W-1:0] first_one(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tag[g] == lk_vpn);
  end

  assign lk_hit   = |match;
  assign lk_idx   = first_one(match);
  assign lk_ppn   = ppn[lk_idx];
  assign lk_attr  = attr[lk_idx];
  assign lk_dirty = dirty[lk_idx];

  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] alloc_idx;
  logic             ev_evict;
  logic             ev_install;

  assign any_free   = ~&valid;
  assign free_idx   = first_one(~valid);
  assign alloc_idx  = ins_reuse ? ins_reuse_idx : (any_free ? free_idx : rr_ptr);
  assign ev_install = ins_en && !flush;
  assign ev_evict   = ev_install && !ins_reuse && !any_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= '0;
      rr_ptr <= '0;
    end else if (flush) begin
      valid  <= '0;
      rr_ptr <= '0;
    end else if (ins_en) begin
      valid[alloc_idx] <= 1'b1;
      if (ev_evict) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ev_install) begin
      tag[alloc_idx]   <= ins_vpn;
      ppn[alloc_idx]   <= ins_ppn;
      attr[alloc_idx]  <= ins_attr;
      dirty[alloc_idx] <= ins_dirty;
    end
  end

  assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  assert_install_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_install |=> valid[$past(alloc_idx)]);

  assert_free_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_install && !ins_reuse && any_free) |-> !valid[alloc_idx]);
endmodule

// File: rtl/atc_top.sv
module atc_top
  import atc_pkg::*;
#(
  parameter int ENTRIES   = 64,
  parameter int NWIN      = 2,
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xlate_en,
  input  logic                   flush,
  input  logic [1:0]             def_cmode,
  input  logic                   def_wprot,
  input  logic [1:0]             def_user,
  input  logic [NWIN-1:0]        win_en,
  input  logic [NWIN*8-1:0]      win_base,
  input  logic [NWIN*8-1:0]      win_mask,
  input  logic [NWIN*2-1:0]      win_cmode,
  input  logic [NWIN-1:0]        win_wprot,
  input  logic [NWIN*2-1:0]      win_user,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [AW-1:0]          req_addr,
  input  logic                   req_write,
  output logic                   resp_valid,
  output logic [AW-1:0]          resp_paddr,
  output logic [1:0]             resp_cmode,
  output logic                   resp_wprot,
  output logic [1:0]             resp_user,
  output logic [1:0]             resp_src,
  output logic                   walk_req,
  output logic [AW-PAGE_BITS-1:0] walk_vpn,
  output logic                   walk_write,
  input  logic                   walk_ack,
  input  logic [AW-PAGE_BITS-1:0] walk_ppn,
  input  logic [1:0]             walk_cmode,
  input  logic                   walk_wprot,
  input  logic [1:0]             walk_user
);
  localparam int VPN_W = AW - PAGE_BITS;
  localparam int IDX_W = $clog2(ENTRIES);

  typedef enum logic {ST_IDLE, ST_WALK} st_e;
  st_e state;

  logic [VPN_W-1:0]     req_vpn;
  logic [PAGE_BITS-1:0] req_off;
  assign req_vpn = req_addr[AW-1:PAGE_BITS];
  assign req_off = req_addr[PAGE_BITS-1:0];

  logic      win_any;
  atc_attr_t win_attr;

  atc_window #(.NWIN(NWIN), .AW(AW)) u_win (
    .addr(req_addr), .en(win_en), .base(win_base), .mask(win_mask),
    .cmode(win_cmode), .wprot(win_wprot), .user(win_user),
    .any_hit(win_any), .attr(win_attr)
  );

  logic             lk_hit, lk_dirty;
  logic [IDX_W-1:0] lk_idx;
  logic [VPN_W-1:0] lk_ppn;
  atc_attr_t        lk_attr;
  logic             ins_en;
  logic             pend_reuse;
  logic [IDX_W-1:0] pend_idx;
  logic [PAGE_BITS-1:0] pend_off;
  atc_attr_t        walk_attr;

  assign walk_attr = '{cmode: walk_cmode, wprot: walk_wprot, user: walk_user};
  assign ins_en    = (state == ST_WALK) && walk_ack;

  atc_tag_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(VPN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(req_vpn), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ppn(lk_ppn),
    .lk_attr(lk_attr), .lk_dirty(lk_dirty),
    .ins_en(ins_en), .ins_reuse(pend_reuse), .ins_reuse_idx(pend_idx),
    .ins_vpn(walk_vpn), .ins_ppn(walk_ppn), .ins_attr(walk_attr),
    .ins_dirty(walk_write)
  );

  // named events for the assertions
  logic ev_accept, ev_off, ev_win_hit, ev_cache_hit, ev_clean_write, ev_miss;
  assign req_ready      = (state == ST_IDLE);
  assign ev_accept      = req_valid && req_ready;
  assign ev_off         = ev_accept && !xlate_en;
  assign ev_win_hit     = ev_accept && xlate_en && win_any;
  assign ev_clean_write = lk_hit && req_write && !lk_dirty;
  assign ev_cache_hit   = ev_accept && xlate_en && !win_any && lk_hit && !ev_clean_write;
  assign ev_miss        = ev_accept && xlate_en && !win_any && (!lk_hit || ev_clean_write);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_paddr <= '0;
      resp_cmode <= '0;
      resp_wprot <= 1'b0;
      resp_user  <= '0;
      resp_src   <= SRC_DEF;
      walk_req   <= 1'b0;
      walk_vpn   <= '0;
      walk_write <= 1'b0;
      pend_reuse <= 1'b0;
      pend_idx   <= '0;
      pend_off   <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (state == ST_IDLE) begin
        if (ev_off) begin
          resp_valid <= 1'b1;
          resp_paddr <= req_addr;
          {resp_cmode, resp_wprot, resp_user} <= {def_cmode, def_wprot, def_user};
          resp_src   <= SRC_DEF;
        end else if (ev_win_hit) begin
          resp_valid <= 1'b1;
          resp_paddr <= req_addr;
          {resp_cmode, resp_wprot, resp_user} <= win_attr;
          resp_src   <= SRC_WIN;
        end else if (ev_cache_hit) begin
          resp_valid <= 1'b1;
          resp_paddr <= {lk_ppn, req_off};
          {resp_cmode, resp_wprot, resp_user} <= lk_attr;
          resp_src   <= SRC_CACHE;
        end else if (ev_miss) begin
          state      <= ST_WALK;
          walk_req   <= 1'b1;
          walk_vpn   <= req_vpn;
          walk_write <= req_write;
          pend_off   <= req_off;
          pend_reuse <= lk_hit && !flush;
          pend_idx   <= lk_idx;
        end
      end else begin
        if (flush) pend_reuse <= 1'b0;
        if (walk_ack) begin
          state      <= ST_IDLE;
          walk_req   <= 1'b0;
          resp_valid <= 1'b1;
          resp_paddr <= {walk_ppn, pend_off};
          {resp_cmode, resp_wprot, resp_user} <= walk_attr;
          resp_src   <= SRC_REFILL;
        end
      end
    end
  end

  assert_off_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_off |=> resp_valid && resp_src == SRC_DEF && resp_paddr == $past(req_addr));

  assert_win_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_win_hit |=> resp_valid && resp_src == SRC_WIN && resp_paddr == $past(req_addr));

  assert_hit_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cache_hit |=> resp_valid && resp_src == SRC_CACHE
                     && resp_paddr[PAGE_BITS-1:0] == $past(req_off));

  assert_miss_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> walk_req && walk_vpn == $past(req_vpn) && !resp_valid);

  assert_walk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_ack) |=> walk_req && $stable(walk_vpn));

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !req_ready);

  assert_refill_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && walk_ack) |=> resp_valid && resp_src == SRC_REFILL && !walk_req);

  assert_clean_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && xlate_en && !win_any && ev_clean_write) |=> walk_req && walk_write);
endmodule

// File: tb/tb_atc_top.sv
`timescale 1ns/1ps
module tb_atc_top;
  localparam int N  = 64;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic xlate_en = 1'b0, flush = 1'b0;
  logic [1:0] def_cmode = 2'd3, def_user = 2'd1;
  logic def_wprot = 1'b1;
  logic [1:0] win_en = '0;
  logic [15:0] win_base = '0, win_mask = '0;
  logic [3:0] win_cmode = '0, win_user = '0;
  logic [1:0] win_wprot = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, resp_valid, resp_wprot, walk_req, walk_write;
  logic [AW-1:0] resp_paddr;
  logic [1:0] resp_cmode, resp_user, resp_src;
  logic [19:0] walk_vpn;
  logic walk_ack = 1'b0, walk_wprot = 1'b0;
  logic [19:0] walk_ppn = '0;
  logic [1:0] walk_cmode = '0, walk_user = '0;

  atc_top #(.ENTRIES(N), .NWIN(2), .AW(AW), .PAGE_BITS(12)) dut (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .flush(flush),
    .def_cmode(def_cmode), .def_wprot(def_wprot), .def_user(def_user),
    .win_en(win_en), .win_base(win_base), .win_mask(win_mask),
    .win_cmode(win_cmode), .win_wprot(win_wprot), .win_user(win_user),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_cmode(resp_cmode), .resp_wprot(resp_wprot), .resp_user(resp_user),
    .resp_src(resp_src), .walk_req(walk_req), .walk_vpn(walk_vpn),
    .walk_write(walk_write), .walk_ack(walk_ack), .walk_ppn(walk_ppn),
    .walk_cmode(walk_cmode), .walk_wprot(walk_wprot), .walk_user(walk_user)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench page table model
  function automatic logic [19:0] m_ppn(input logic [19:0] v);
    return v ^ 20'h5A5A5;
  endfunction
  function automatic logic [4:0] m_attr(input logic [19:0] v);
    return {v[1:0], v[2], v[4:3]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // results of the last access
  logic [1:0] r_src; logic [31:0] r_pa; logic [4:0] r_at;
  bit r_ok, r_walked, r_wwr, r_stall;
  logic [19:0] r_wvpn;

  task automatic access(input logic [31:0] a, input bit w);
    int n;
    @(negedge clk);
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    r_walked = 1'b0; r_stall = 1'b1; r_wvpn = '0; r_wwr = 1'b0;
    if (!resp_valid && walk_req) begin
      r_walked = 1'b1;
      r_wvpn = walk_vpn; r_wwr = walk_write; r_stall = !req_ready;
      walk_ack = 1'b1;
      walk_ppn = m_ppn(walk_vpn);
      {walk_cmode, walk_wprot, walk_user} = m_attr(walk_vpn);
      @(negedge clk);
      walk_ack = 1'b0;
    end
    r_ok = resp_valid; r_src = resp_src; r_pa = resp_paddr;
    r_at = {resp_cmode, resp_wprot, resp_user};
  endtask

  // {addr, write, expected source}
  localparam logic [34:0] VEC [10] = '{
    {32'h0000_1000, 1'b0, 2'd3},
    {32'h0000_1ABC, 1'b0, 2'd2},
    {32'h0000_1004, 1'b1, 2'd3},
    {32'h0000_1008, 1'b1, 2'd2},
    {32'h0000_2000, 1'b1, 2'd3},
    {32'h0000_2FFF, 1'b0, 2'd2},
    {32'h4800_0000, 1'b0, 2'd3},
    {32'h4800_0010, 1'b0, 2'd2},
    {32'hFFFF_F123, 1'b0, 2'd3},
    {32'hFFFF_F321, 1'b1, 2'd3}
  };

  task automatic check_xlated(input string tag, input logic [31:0] a);
    chk({tag, " paddr"}, r_pa, {m_ppn(a[31:12]), a[11:0]});
    chk({tag, " attr"}, {27'd0, r_at}, {27'd0, m_attr(a[31:12])});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 resp_valid", {31'd0, resp_valid}, 32'd0);
    chk("R11 walk_req", {31'd0, walk_req}, 32'd0);
    chk("R11 req_ready", {31'd0, req_ready}, 32'd1);

    // R1 translation off
    access(32'h1234_5678, 1'b1);
    chk("R1 valid", {31'd0, r_ok}, 32'd1);
    chk("R1 src", {30'd0, r_src}, 32'd0);
    chk("R1 paddr", r_pa, 32'h1234_5678);
    chk("R1 attr", {27'd0, r_at}, {27'd0, 5'b11_1_01});
    chk("R1 no walk", {31'd0, r_walked}, 32'd0);

    // R11 empty after reset: first translated lookup misses
    xlate_en = 1'b1;
    // table walk: R4 hits, R5/R6 refills, R7 clean-write upgrade
    for (int i = 0; i < 10; i++) begin
      logic [31:0] a; bit w; logic [1:0] s;
      {a, w, s} = VEC[i];
      access(a, w);
      chk($sformatf("R4/R6 vec%0d src", i), {30'd0, r_src}, {30'd0, s});
      chk($sformatf("R4/R6 vec%0d valid", i), {31'd0, r_ok}, 32'd1);
      check_xlated($sformatf("R4/R6 vec%0d", i), a);
      if (s == 2'd3) begin
        chk($sformatf("R5 vec%0d vpn", i), {12'd0, r_wvpn}, {12'd0, a[31:12]});
        chk($sformatf("R5/R7 vec%0d walk_write", i), {31'd0, r_wwr}, {31'd0, w});
        chk($sformatf("R5 vec%0d stall", i), {31'd0, r_stall}, 32'd1);
      end
    end

    // R2/R3 windows: win0 0x40 mask 0x0F, win1 0x48 mask 0x37
    win_base = {8'h48, 8'h40}; win_mask = {8'h37, 8'h0F};
    win_cmode = {2'd2, 2'd1}; win_wprot = 2'b01; win_user = {2'd2, 2'd1};
    win_en = 2'b11;
    access(32'h4800_0040, 1'b0);
    chk("R3 win0 over win1 and cache src", {30'd0, r_src}, 32'd1);
    chk("R3 win0 attr", {27'd0, r_at}, {27'd0, 5'b01_1_01});
    chk("R2 identity", r_pa, 32'h4800_0040);
    access(32'h5800_0123, 1'b1);
    chk("R2 win1 src", {30'd0, r_src}, 32'd1);
    chk("R2 win1 attr", {27'd0, r_at}, {27'd0, 5'b10_0_10});
    chk("R2 win1 paddr", r_pa, 32'h5800_0123);
    access(32'h4100_0000, 1'b0);
    chk("R2 mask win0 attr", {27'd0, r_at}, {27'd0, 5'b01_1_01});
    win_en = 2'b10;
    access(32'h4800_0040, 1'b0);
    chk("R2 disabled win0 -> win1 attr", {27'd0, r_at}, {27'd0, 5'b10_0_10});
    win_en = 2'b00;
    access(32'h4800_0040, 1'b0);
    chk("R2 windows off -> cache src", {30'd0, r_src}, 32'd2);
    check_xlated("R2 windows off", 32'h4800_0040);

    // R9 flush
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
    access(32'h0000_1000, 1'b0);
    chk("R9 after flush src", {30'd0, r_src}, 32'd3);
    access(32'h0000_2000, 1'b0);
    chk("R9 second page misses", {31'd0, r_walked}, 32'd1);

    // R8 replacement
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
    for (int i = 0; i < N; i++) begin
      access({20'h00100 + 20'(i), 12'h000}, 1'b0);
      if (i == 0 || i == N - 1)
        chk($sformatf("R8 fill %0d walks", i), {31'd0, r_walked}, 32'd1);
    end
    access(32'h0010_0008, 1'b0);
    chk("R8 full cache page0 still hits", {30'd0, r_src}, 32'd2);
    access(32'h0020_0000, 1'b0);
    chk("R8 new page walks", {31'd0, r_walked}, 32'd1);
    access(32'h0010_1000, 1'b0);
    chk("R8 slot1 survives", {30'd0, r_src}, 32'd2);
    access(32'h0010_0000, 1'b0);
    chk("R8 slot0 evicted", {30'd0, r_src}, 32'd3);
    access(32'h0010_1000, 1'b0);
    chk("R8 slot1 evicted next", {30'd0, r_src}, 32'd3);
    access(32'h0010_3000, 1'b0);
    chk("R8 slot3 survives", {30'd0, r_src}, 32'd2);
    access(32'h0020_0ABC, 1'b0);
    chk("R8 installed page hits", {30'd0, r_src}, 32'd2);
    check_xlated("R8 installed page", 32'h0020_0ABC);

    // R7 read of a clean page hits; its write walks once
    access(32'h0010_3004, 1'b1);
    chk("R7 clean write walks", {31'd0, r_wwr}, 32'd1);
    access(32'h0010_3008, 1'b1);
    chk("R7 dirty write hits", {30'd0, r_src}, 32'd2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule